// File: doc/BRIEF.md
# Branch Target Address Generator

This block produces the next fetch address for a microcontroller with a 64 KB code space. Each request carries the address of the first byte of the instruction that follows the branch, a two-bit format code, the operand fields taken from the instruction, and a taken flag. The flag is produced by condition logic outside this block. The block picks one of four sources for the next address. It can fall through to the following instruction. It can jump inside the current 2 KB page using an 11-bit field. It can jump by a signed 8-bit displacement. It can load a full 16-bit absolute target.

The in-page and displacement forms are both based on the address of the following instruction, never on the address of the branch itself. The result is registered and appears one clock after the request strobe, together with a valid flag. Opcode decode, operand fetch, condition evaluation and return-address handling are done by the surrounding pipeline.

Top module: `branch_target_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `nxt_vld` is 0 and `nxt_pc` is 0x0000.
- R2: `nxt_vld` is 1 in the cycle after a cycle with `req_vld` high, and 0 in the cycle after a cycle with `req_vld` low.
- R3: When `req_vld` is low, `nxt_pc` keeps its previous value.
- R4: With `req_vld` high and `taken` low, `nxt_pc` becomes `fall_pc` for every format code.
- R5: Format code 0 (sequential) gives `fall_pc` whatever the value of `taken`.
- R6: Format code 1 (in-page) with `taken` high gives {`fall_pc`[15:11], `pg_sel`[2:0], `opnd_lo`[7:0]}. The target therefore stays in the 2 KB page of the following instruction.
- R7: Format code 2 (relative) with `taken` high gives `fall_pc` plus `opnd_lo`, read as a two's-complement value from -128 to +127, modulo 65536.
- R8: Format code 3 (absolute) with `taken` high gives {`opnd_hi`, `opnd_lo`}.
- R9: `opnd_hi` has no effect in formats 0, 1 and 2, and `pg_sel` has no effect in formats 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| fmt | input | 2 | Format: 0 sequential, 1 in-page, 2 relative, 3 absolute |
| taken | input | 1 | Branch condition result |
| fall_pc | input | 16 | Address of the first byte of the following instruction |
| pg_sel | input | 3 | In-page field bits 10:8, from the opcode |
| opnd_lo | input | 8 | Low operand byte: displacement or address bits 7:0 |
| opnd_hi | input | 8 | High operand byte of the absolute target |
| nxt_vld | output | 1 | Next address valid |
| nxt_pc | output | 16 | Next fetch address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 11-bit in-page field and an 8-bit displacement. At these widths every one of the 256 displacements can be applied at several base addresses. These include bases where the sum wraps past 0xFFFF or below 0x0000, and bases that sit on a 2 KB page edge.

All eight page-select values are combined with every low operand byte, at bases at the bottom and top of a page. Fields that a format ignores are driven with changing junk values, and the bench checks that the result does not depend on them.

// File: rtl/btg_pkg.sv
package btg_pkg;
    typedef enum logic [1:0] {
        FMT_SEQ  = 2'd0,
        FMT_PAGE = 2'd1,
        FMT_REL  = 2'd2,
        FMT_ABS  = 2'd3
    } btg_fmt_e;
endpackage

// File: rtl/btg_page_calc.sv
module btg_page_calc #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 11,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-PAGE_W-1:0] base_hi,
    input  logic [PAGE_W-OFS_W-1:0]  pg_sel,
    input  logic [OFS_W-1:0]         lo,
    output logic [ADDR_W-1:0]        tgt
);
    // upper bits are kept from the following instruction, the page offset is replaced
    always_comb begin
        tgt = {base_hi, pg_sel, lo};
    end
endmodule

// File: rtl/btg_rel_calc.sv
module btg_rel_calc #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  disp,
    output logic [ADDR_W-1:0] tgt
);
    localparam int EXT_W = ADDR_W - OFS_W;
    logic [ADDR_W-1:0] disp_x;

    always_comb begin
        disp_x = {{EXT_W{disp[OFS_W-1]}}, disp};
        tgt    = base + disp_x; // wraps modulo 2**ADDR_W
    end
endmodule

// File: rtl/btg_abs_calc.sv
module btg_abs_calc #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-OFS_W-1:0] hi,
    input  logic [OFS_W-1:0]        lo,
    output logic [ADDR_W-1:0]       tgt
);
    always_comb begin
        tgt = {hi, lo};
    end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import btg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 11,
    parameter int OFS_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_vld,
    input  logic [1:0]               fmt,
    input  logic                     taken,
    input  logic [ADDR_W-1:0]        fall_pc,
    input  logic [PAGE_W-OFS_W-1:0]  pg_sel,
    input  logic [OFS_W-1:0]         opnd_lo,
    input  logic [ADDR_W-OFS_W-1:0]  opnd_hi,
    output logic                     nxt_vld,
    output logic [ADDR_W-1:0]        nxt_pc
);
    localparam int HI_W  = ADDR_W - PAGE_W;
    localparam int SEL_W = PAGE_W - OFS_W;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pc;
    } st_t;

    st_t st_d, st_q;
    btg_fmt_e fmt_e;
    logic [ADDR_W-1:0] page_tgt, rel_tgt, abs_tgt;

    btg_page_calc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_page (
        .base_hi (fall_pc[ADDR_W-1:PAGE_W]),
        .pg_sel  (pg_sel),
        .lo      (opnd_lo),
        .tgt     (page_tgt)
    );

    btg_rel_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_rel (
        .base (fall_pc),
        .disp (opnd_lo),
        .tgt  (rel_tgt)
    );

    btg_abs_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_abs (
        .hi  (opnd_hi),
        .lo  (opnd_lo),
        .tgt (abs_tgt)
    );

    always_comb begin
        fmt_e     = btg_fmt_e'(fmt);
        st_d      = st_q;
        st_d.vld  = req_vld;
        if (req_vld) begin
            st_d.pc = fall_pc;
            if (taken) begin
                unique case (fmt_e)
                    FMT_PAGE: st_d.pc = page_tgt;
                    FMT_REL:  st_d.pc = rel_tgt;
                    FMT_ABS:  st_d.pc = abs_tgt;
                    default:  st_d.pc = fall_pc;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_vld = st_q.vld;
    assign nxt_pc  = st_q.pc;

    // ---------------- assertions ----------------
    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> nxt_vld);
    assert_vld_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !nxt_vld);
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_vld && $past(rst_n)) |=> $stable(nxt_pc));
    assert_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !taken) |=> nxt_pc == $past(fall_pc));
    assert_seq_fmt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && fmt == 2'd0) |=> nxt_pc == $past(fall_pc));
    assert_same_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && taken && fmt == 2'd1)
        |=> nxt_pc[ADDR_W-1:PAGE_W] == $past(fall_pc[ADDR_W-1:PAGE_W]));
    assert_abs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && taken && fmt == 2'd3) |=> nxt_pc == $past({opnd_hi, opnd_lo}));

    always_comb begin
        if (rst_n && req_vld && taken && fmt == 2'd1) begin
            assert_page_field_R6: assert (page_tgt[PAGE_W-1:0] == {pg_sel, opnd_lo});
        end
    end

    if (SEL_W < 1 || HI_W < 1) begin : g_bad_cfg
        initial $error("branch_target_gen: PAGE_W must lie between OFS_W and ADDR_W");
    end
endmodule

// File: tb/branch_target_gen_test.sv
`timescale 1ns/1ps
module branch_target_gen_test;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        taken = 1'b0;
    logic [15:0] fall_pc = 16'h0;
    logic [2:0]  pg_sel = 3'd0;
    logic [7:0]  opnd_lo = 8'h0;
    logic [7:0]  opnd_hi = 8'h0;
    logic        nxt_vld;
    logic [15:0] nxt_pc;

    int n_run = 0;
    int n_fail = 0;

    always #(TCK/2) clk = ~clk;

    branch_target_gen uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .fmt(fmt), .taken(taken),
        .fall_pc(fall_pc), .pg_sel(pg_sel), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi),
        .nxt_vld(nxt_vld), .nxt_pc(nxt_pc)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, result appears after the next rising edge
    task automatic issue(input logic [1:0] f, input logic t, input logic [15:0] pc,
                         input logic [2:0] ps, input logic [7:0] lo, input logic [7:0] hi,
                         input string req, input logic [15:0] exp);
        fmt = f; taken = t; fall_pc = pc; pg_sel = ps; opnd_lo = lo; opnd_hi = hi;
        req_vld = 1'b1;
        @(negedge clk);
        chk(req, {15'd0, nxt_vld}, 16'd1);
        chk(req, nxt_pc, exp);
    endtask

    function automatic logic [15:0] rel_exp(input logic [15:0] pc, input logic [7:0] d);
        int s;
        s = int'(pc) + int'($signed(d));
        return 16'(s & 32'hFFFF);
    endfunction

    initial begin
        logic [15:0] bases [6];
        bases = '{16'h0000, 16'h0005, 16'h07FF, 16'h0800, 16'hFF90, 16'hFFFF};
        repeat (3) @(negedge clk);
        chk("R1 vld", {15'd0, nxt_vld}, 16'd0);
        chk("R1 pc", nxt_pc, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post vld", {15'd0, nxt_vld}, 16'd0);
        chk("R1 post pc", nxt_pc, 16'h0000);

        // R7 relative sweep, R9 junk on opnd_hi / pg_sel
        foreach (bases[b]) begin
            for (int d = 0; d < 256; d++) begin
                issue(2'd2, 1'b1, bases[b], 3'(d), 8'(d), 8'(d * 7 + b),
                      "R7 rel", rel_exp(bases[b], 8'(d)));
            end
        end

        // R6 in-page sweep, R9 junk on opnd_hi
        for (int p = 0; p < 4; p++) begin
            logic [15:0] pc;
            pc = (p == 0) ? 16'h07FF : (p == 1) ? 16'h0800 : (p == 2) ? 16'hF800 : 16'h5ABC;
            for (int s = 0; s < 8; s++) begin
                for (int l = 0; l < 256; l++) begin
                    issue(2'd1, 1'b1, pc, 3'(s), 8'(l), 8'(l ^ 8'h5A), "R6 page",
                          (pc & 16'hF800) | 16'(s << 8) | 16'(l));
                end
            end
        end

        // R8 absolute sweep, R9 junk on pg_sel
        for (int h = 0; h < 256; h++) begin
            for (int l = 0; l < 256; l += 51) begin
                issue(2'd3, 1'b1, 16'(h * 13), 3'(h + l), 8'(l), 8'(h), "R8 abs",
                      {8'(h), 8'(l)});
            end
        end

        // R4 not taken, R5 sequential ignores taken
        for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 64; k++) begin
                logic [15:0] pc;
                pc = 16'(k * 1031 + f);
                issue(2'(f), 1'b0, pc, 3'(k), 8'(k * 3), 8'(k * 5), "R4 not taken", pc);
            end
        end
        for (int k = 0; k < 64; k++) begin
            logic [15:0] pc;
            pc = 16'(k * 997);
            issue(2'd0, 1'b1, pc, 3'(k), 8'(k + 9), 8'(k + 1), "R5 seq", pc);
        end

        // R2 / R3: idle cycles drop valid and hold the address
        issue(2'd3, 1'b1, 16'h1234, 3'd0, 8'hCD, 8'hAB, "R8 abs", 16'hABCD);
        req_vld = 1'b0; fmt = 2'd3; taken = 1'b1; opnd_hi = 8'h11; opnd_lo = 8'h22;
        fall_pc = 16'h9999;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 idle vld", {15'd0, nxt_vld}, 16'd0);
            chk("R3 hold", nxt_pc, 16'hABCD);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule